// File: doc/BRIEF.md
# Nine-Bit Serial Frame Transmitter

This block serializes one data byte onto a single output line. The host writes a byte and, in the same cycle, presents a ninth bit and a framing mode. In the plain shift framing only the eight data bits go out. In the asynchronous framings the data bits are wrapped in a low start bit and a high stop bit. The nine-bit framings also carry the extra bit just before the stop bit. Software can use that extra bit as parity, or set it to one to mark an address frame on a multiprocessor link.

Each bit lasts until the next pulse of an external bit-rate tick. Rate generation and parity computation belong to the surrounding logic. A sticky done flag tells the host that the frame has reached its end. The host clears the flag with a dedicated clear input.

Top module: `ser9_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1 and `tx_done` is 0.
- R2: With `mode` = 2'b00 (shift framing), a frame is exactly 8 bits: data bit 0 first through data bit 7 last, with no start or stop bit.
- R3: With `mode` = 2'b01, a frame is 10 bits: a start bit of 0, data bits 0 to 7 in that order, then a stop bit of 1.
- R4: With `mode` = 2'b10 or 2'b11, a frame is 11 bits: a start bit of 0, data bits 0 to 7, then the `bit9` value captured at the write, then a stop bit of 1.
- R5: A write strobe while idle starts a frame. The first bit appears on `txd` in the cycle after the write. Each `tick` pulse advances one bit, and `txd` does not change between ticks.
- R6: The tick that ends the last bit returns `txd` to 1, and `txd` stays 1 while idle.
- R7: In the asynchronous framings, `tx_done` goes to 1 on the tick that begins the stop bit. In the shift framing, it goes to 1 on the tick that ends bit 7. Once set, it stays 1 until cleared.
- R8: A `done_clr` pulse clears `tx_done` in the next cycle. If `done_clr` arrives in the same cycle as a setting tick, the set wins.
- R9: A write strobe while a frame is in progress is ignored. The frame in flight continues with its original data, ninth bit and framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Buffer write strobe; starts a frame when idle |
| wr_data | input | DATA_W | Byte to transmit |
| bit9 | input | 1 | Ninth bit for the nine-bit framings |
| mode | input | 2 | Framing select (00 shift, 01 ten-bit, 1x eleven-bit) |
| tick | input | 1 | Bit-rate pulse, one cycle wide |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output line, registered |
| tx_done | output | 1 | Sticky frame-done flag, registered |

## Verification
The bench sends bytes with uneven bit patterns in every framing. It checks the bit order, so a design that sent the most significant bit first, or put the ninth bit after the stop bit, would miscompare. It checks the done flag at every bit to catch a flag raised one bit early or late, such as at frame end instead of at stop-bit entry in the asynchronous framings. It writes a second byte in the middle of a frame, which exposes a design that reloads its shifter when busy. It pulses the clear in the same cycle as the setting tick, which exposes a design that gives the clear priority.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  typedef enum logic [1:0] {
    FRM_SHIFT  = 2'b00,
    FRM_ASYNC8 = 2'b01,
    FRM_NINE_A = 2'b10,
    FRM_NINE_B = 2'b11
  } frm_mode_e;
endpackage

// File: rtl/ser9_fmt.sv
// Builds the LSB-first bit vector of one frame and its length in bits.
module ser9_fmt #(
  parameter int DW = 8,
  localparam int FW = DW + 3,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic [DW-1:0]         data,
  input  logic                  b9,
  input  ser9_pkg::frm_mode_e   mode,
  output logic [FW-1:0]         frame,
  output logic [CW-1:0]         len,
  output logic                  framed
);
  always_comb begin
    frame  = '1;
    len    = CW'(FW);
    framed = 1'b1;
    case (mode)
      ser9_pkg::FRM_SHIFT: begin
        frame[DW-1:0] = data;
        len           = CW'(DW);
        framed        = 1'b0;
      end
      ser9_pkg::FRM_ASYNC8: begin
        frame[DW:0] = {data, 1'b0};
        len         = CW'(DW + 2);
      end
      default: begin
        frame[DW+1:0] = {b9, data, 1'b0};
        len           = CW'(FW);
      end
    endcase
  end
endmodule

// File: rtl/ser9_shift.sv
// Shift engine: loads a frame when idle and advances one bit per tick.
module ser9_shift #(
  parameter int DW = 8,
  localparam int FW = DW + 3,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] len,
  input  logic          framed,
  input  logic          tick,
  output logic          txd,
  output logic          busy,
  output logic          set_done
);
  logic [FW-1:0] sreg;
  logic [CW-1:0] left;
  logic          has_stop;

  always_comb begin
    set_done = 1'b0;
    if (busy && tick) begin
      if (has_stop) set_done = (left == CW'(2));
      else          set_done = (left == CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '1;
      left     <= '0;
      has_stop <= 1'b0;
      busy     <= 1'b0;
      txd      <= 1'b1;
    end else if (load) begin
      sreg     <= frame;
      left     <= len;
      has_stop <= framed;
      busy     <= 1'b1;
      txd      <= frame[0];
    end else if (busy && tick) begin
      if (left == CW'(1)) begin
        busy <= 1'b0;
        txd  <= 1'b1;
        left <= '0;
      end else begin
        sreg <= {1'b1, sreg[FW-1:1]};
        txd  <= sreg[1];
        left <= left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/ser9_flag.sv
// Sticky done flag; set has priority over clear.
module ser9_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9,
  input  logic [1:0]        mode,
  input  logic              tick,
  input  logic              done_clr,
  output logic              txd,
  output logic              tx_done
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame;
  logic [CW-1:0] len;
  logic          framed;
  logic          busy;
  logic          set_done;
  logic          load;

  assign load = wr_stb && !busy;

  ser9_fmt #(.DW(DATA_W)) u_fmt (
    .data(wr_data), .b9(bit9), .mode(ser9_pkg::frm_mode_e'(mode)),
    .frame(frame), .len(len), .framed(framed)
  );

  ser9_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .frame(frame), .len(len),
    .framed(framed), .tick(tick), .txd(txd), .busy(busy),
    .set_done(set_done)
  );

  ser9_flag u_flag (
    .clk(clk), .rst(rst), .set(set_done), .clr(done_clr), .q(tx_done)
  );
endmodule

// File: rtl/ser9_tx_chk.sv
module ser9_tx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_stb,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    mode,
  input logic          tick,
  input logic          done_clr,
  input logic          txd,
  input logic          tx_done,
  input logic          busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy && mode != 2'b00) |=> !txd); // R3
  AST_SHIFT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy && mode == 2'b00) |=> (txd == $past(wr_data[0]))); // R2
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(txd)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !done_clr) |=> tx_done); // R7
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !busy) |=> !tx_done); // R8
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> busy); // R9
endmodule

bind ser9_tx ser9_tx_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .mode(mode),
  .tick(tick), .done_clr(done_clr), .txd(txd), .tx_done(tx_done),
  .busy(busy)
);

// File: tb/ser9_tx_bench.sv
module ser9_tx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit9 = 1'b0;
  logic [1:0] mode = '0;
  logic       tick = 1'b0;
  logic       done_clr = 1'b0;
  logic       txd;
  logic       tx_done;

  int vec = 0;
  int bad = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  ser9_tx #(.DATA_W(8)) u_ser9_tx (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .bit9(bit9),
    .mode(mode), .tick(tick), .done_clr(done_clr), .txd(txd),
    .tx_done(tx_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: pushes expected line bits, then runs the frame while the monitor
  // pops and compares each bit at negedges between ticks.
  task automatic send(input logic [7:0] d, input logic b, input logic [1:0] m,
                      input bit clr_at_set, input bit intrude);
    int len;
    bit framed;
    framed = (m != 2'b00);
    if (framed) exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    if (m[1]) exp_q.push_back(b);
    if (framed) exp_q.push_back(1'b1);
    len = exp_q.size();
    wr_data = d; bit9 = b; mode = m; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    for (int k = 0; k < len; k++) begin
      bit e;
      bit set_now;
      e = exp_q.pop_front();
      chk(framed ? (m[1] ? "R4" : "R3") : "R2", txd, e);
      chk("R7", tx_done, framed && (k >= len - 1));
      // hold between ticks; optionally try to overwrite the buffer
      if (intrude && k == 2) begin
        wr_data = ~d; bit9 = ~b; mode = 2'b00; wr_stb = 1'b1;
      end
      @(negedge clk);
      wr_stb = 1'b0; wr_data = d; bit9 = b; mode = m;
      chk(intrude ? "R9" : "R5", txd, e);
      set_now = framed ? (k == len - 2) : (k == len - 1);
      tick = 1'b1;
      done_clr = clr_at_set && set_now;
      @(negedge clk);
      tick = 1'b0; done_clr = 1'b0;
      if (set_now && clr_at_set) chk("R8", tx_done, 1'b1);
    end
    chk("R6", txd, 1'b1);
    chk("R7", tx_done, 1'b1);
    @(negedge clk);
    chk("R6", txd, 1'b1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8", tx_done, 1'b0);
  endtask

  initial begin : watchdog
    #2000000;
    bad++;
    vec++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", txd, 1'b1);
    chk("R1", tx_done, 1'b0);
    // ticks while idle leave the line high
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R6", txd, 1'b1);
    send(8'hA5, 1'b0, 2'b00, 0, 0);
    send(8'h3C, 1'b1, 2'b00, 0, 0);
    send(8'h96, 1'b0, 2'b01, 0, 0);
    send(8'h01, 1'b1, 2'b01, 0, 0);
    send(8'h5A, 1'b1, 2'b10, 0, 0);
    send(8'hF0, 1'b0, 2'b11, 0, 0);
    send(8'h80, 1'b1, 2'b11, 1, 0);
    send(8'hC3, 1'b1, 2'b10, 0, 1);
    send(8'h6E, 1'b0, 2'b01, 0, 1);
    send(8'h81, 1'b0, 2'b00, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule